// File: doc/BRIEF.md
# Double SHA-256 Nonce Search Engine

The block searches for nonces that satisfy a proof-of-work test on an 80-byte header whose first 64 bytes are already condensed into a midstate. A work unit is loaded in a single cycle. The unit is the 256-bit midstate, the three fixed message words that share the second header block with the nonce, and a start nonce. The engine then tries nonces in sequence, one after another. Each trial runs one SHA-256 compression from the midstate over the nonce-bearing block. A second compression from the standard initial hash values follows, over the padded 256-bit first digest.

Only the last word of the second digest is tested, and that word is already settled three rounds before the end. The second compression therefore stops after 61 rounds and compares register e against the negated final initial-hash word. The schedule words of the first compression that do not depend on the nonce are formed once, when the work unit is loaded. A match raises a one-cycle strobe and updates a register with the nonce that produced it. Loading a new work unit clears both and abandons the trial in flight.

Top module: `dsha_nonce_tester`

## Requirements
- R1: After reset, `hit_o` is 0 and `golden_o` is 0, and they stay so until a work unit is loaded.
- R2: The trials use the start nonce, then increment it by one each trial, wrapping from 0xFFFFFFFF to 0. Each nonce is tried exactly once, and hits are reported in nonce order.
- R3: The first compression starts from the midstate, with word 0 = `midstate_i[255:224]` through word 7 = `midstate_i[31:0]`. Its block is w0 = `tail_i[95:64]`, w1 = `tail_i[63:32]`, w2 = `tail_i[31:0]`, w3 = nonce, w4 = 0x80000000, w5..w14 = 0 and w15 = 640. Its digest is the midstate plus the final working state, word by word.
- R4: The second compression starts from the standard SHA-256 initial hash values. Its block is the eight first-digest words, then 0x80000000, then six zero words, then 256.
- R5: A nonce is a hit when (last word of the second digest) AND `HIT_MASK` equals 0. The default mask is 0xFFFFFFFF, so the whole word must be zero.
- R6: The midstate, the tail words and the start nonce are captured only in the load cycle. Changing these ports afterwards has no effect on the search.
- R7: `hit_o` is high for exactly one cycle per hit. `golden_o` takes the hit nonce in that same cycle and holds it until the next hit or load.
- R8: A load pulse clears `hit_o` and `golden_o` on the next cycle, discards the trial in flight and restarts at the new start nonce.
- R9: The hit of trial k (k = 0 for the start nonce) is visible 126·(k+1) clock edges after the edge that samples `load_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load a new work unit this cycle |
| midstate_i | input | 256 | Midstate of the first header block, word 0 in the top bits |
| tail_i | input | 96 | Three fixed message words of the second block, w0 in the top bits |
| nonce_start_i | input | 32 | First nonce of the work unit |
| hit_o | output | 1 | One-cycle strobe on a qualifying nonce |
| golden_o | output | 32 | Most recent qualifying nonce |

## Verification
The bench builds a reference in which both compressions run all 64 rounds and the full final word is added. A design whose early exit compares the wrong register, the wrong round or the wrong constant therefore reports different nonces. The bench uses a low-bit mask so that hits are frequent. It checks the arrival cycle of every hit against R9, which catches an off-by-one nonce correction or extra pipeline cycles. Other runs drive garbage onto the work-unit ports after loading, start the count near the nonce wrap point, and reload mid-trial. A design that re-reads its inputs, overflows wrongly or finishes an abandoned trial shows an extra, missing or misnamed hit.

// File: rtl/dsha_pkg.sv
// Shared types, constants and SHA-256 helper functions for the nonce search engine.
// Assumes 32-bit words, word 0 of any state or block stored at index 0.
package dsha_pkg;
    typedef logic [31:0] word_t;
    typedef logic [7:0][31:0] hstate_t;   // index 0 = a ... index 7 = h
    typedef logic [15:0][31:0] block_t;   // index 0 = w0

    localparam word_t PAD_WORD = 32'h8000_0000;
    localparam word_t LEN_FIRST = 32'd640;
    localparam word_t LEN_SECOND = 32'd256;

    localparam word_t IV_TAB [8] = '{
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

    localparam word_t K_TAB [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction
endpackage

// File: rtl/dsha_round.sv
// One SHA-256 round, purely combinational.
// Assumes the caller supplies the round constant and schedule word of this round.
module dsha_round
    import dsha_pkg::*;
(
    input  hstate_t st_i,
    input  word_t   k_i,
    input  word_t   w_i,
    output hstate_t st_o
);
    word_t t1, t2;

    // Compute the two temporaries and shift the working registers.
    always_comb begin
        t1 = st_i[7] + big_sig1(st_i[4]) + ((st_i[4] & st_i[5]) ^ (~st_i[4] & st_i[6])) + k_i + w_i;
        t2 = big_sig0(st_i[0]) + ((st_i[0] & st_i[1]) ^ (st_i[0] & st_i[2]) ^ (st_i[1] & st_i[2]));
        st_o[0] = t1 + t2;
        st_o[1] = st_i[0];
        st_o[2] = st_i[1];
        st_o[3] = st_i[2];
        st_o[4] = st_i[3] + t1;
        st_o[5] = st_i[4];
        st_o[6] = st_i[5];
        st_o[7] = st_i[6];
    end
endmodule

// File: rtl/dsha_sched.sv
// Sliding 16-word message-schedule window. Presents w[t] and extends by one word per step.
// Assumes rnd_i is the round being executed. With use_pre_i set, words 16, 17 and the
// nonce-free part of word 18 come from values held for the work unit.
module dsha_sched
    import dsha_pkg::*;
#(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en_i,
    input  block_t        ld_blk_i,
    input  logic          step_i,
    input  logic          use_pre_i,
    input  logic [RW-1:0] rnd_i,
    input  word_t         pre16_i,
    input  word_t         pre17_i,
    input  word_t         pre18_i,
    output word_t         w_o
);
    block_t win;
    word_t  nxt;

    // Choose between a held word and the generic recurrence.
    always_comb begin
        nxt = small_sig1(win[14]) + win[9] + small_sig0(win[1]) + win[0];
        if (use_pre_i && rnd_i == RW'(0))      nxt = pre16_i;
        else if (use_pre_i && rnd_i == RW'(1)) nxt = pre17_i;
        else if (use_pre_i && rnd_i == RW'(2)) nxt = pre18_i + small_sig0(win[1]);
    end

    // Load a fresh block or slide the window by one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (ld_en_i) begin
            win <= ld_blk_i;
        end else if (step_i) begin
            for (int i = 0; i < 15; i++) win[i] <= win[i+1];
            win[15] <= nxt;
        end
    end

    assign w_o = win[0];
endmodule

// File: rtl/dsha_nonce_tester.sv
// Iterative double SHA-256 nonce search with a shortened second pass.
// Each trial takes one issue cycle, 64 first-pass rounds and 61 second-pass rounds.
// Assumes load_i is a single-cycle pulse. Runs continuously after a load.
module dsha_nonce_tester
    import dsha_pkg::*;
#(
    parameter logic [31:0] HIT_MASK = 32'hFFFF_FFFF,
    parameter int ROUNDS = 64,
    parameter int SKIP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [255:0] midstate_i,
    input  logic [95:0]  tail_i,
    input  logic [31:0]  nonce_start_i,
    output logic         hit_o,
    output logic [31:0]  golden_o
);
    localparam int RW = $clog2(ROUNDS);
    localparam logic [RW-1:0] P1_LAST = RW'(ROUNDS - 1);
    localparam logic [RW-1:0] P2_LAST = RW'(ROUNDS - SKIP - 1);
    localparam word_t NEG_H7 = 32'd0 - IV_TAB[7];

    typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_P1, PH_P2} phase_t;

    phase_t        ph;
    logic [RW-1:0] rnd;
    hstate_t       mid_q, st_q, st_nxt, mid_in, iv_st;
    logic [2:0][31:0] tw_q;
    word_t         pre16, pre17, pre18, cnt_q, w_cur;
    word_t         ld16, ld17;
    block_t        blk1, blk2, ld_blk;
    logic          match, sched_ld;

    // Unpack the midstate and form the work-unit schedule words from the load ports.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            mid_in[i] = midstate_i[255-32*i -: 32];
            iv_st[i]  = IV_TAB[i];
        end
        ld16 = tail_i[95:64] + small_sig0(tail_i[63:32]);
        ld17 = tail_i[63:32] + small_sig0(tail_i[31:0]) + small_sig1(LEN_FIRST);
    end

    // Assemble the nonce-bearing block and the padded second-pass block.
    always_comb begin
        blk1 = '0;
        blk1[0] = tw_q[0];
        blk1[1] = tw_q[1];
        blk1[2] = tw_q[2];
        blk1[3] = cnt_q;
        blk1[4] = PAD_WORD;
        blk1[15] = LEN_FIRST;
        blk2 = '0;
        for (int i = 0; i < 8; i++) blk2[i] = mid_q[i] + st_nxt[i];
        blk2[8] = PAD_WORD;
        blk2[15] = LEN_SECOND;
        sched_ld = (ph == PH_ISSUE) || (ph == PH_P1 && rnd == P1_LAST);
        ld_blk = (ph == PH_ISSUE) ? blk1 : blk2;
    end

    dsha_sched #(.RW(RW)) u_sched (
        .clk(clk), .rst_n(rst_n), .ld_en_i(sched_ld), .ld_blk_i(ld_blk),
        .step_i(ph == PH_P1 || ph == PH_P2), .use_pre_i(ph == PH_P1), .rnd_i(rnd),
        .pre16_i(pre16), .pre17_i(pre17), .pre18_i(pre18), .w_o(w_cur));

    dsha_round u_round (.st_i(st_q), .k_i(K_TAB[rnd]), .w_i(w_cur), .st_o(st_nxt));

    // Early-exit test: e after the shortened pass against the negated last IV word.
    assign match = ((st_nxt[4] ^ NEG_H7) & HIT_MASK) == 32'd0;

    // Sequence the work unit, the two passes and the hit report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;
            rnd <= '0;
            mid_q <= '0;
            st_q <= '0;
            tw_q <= '0;
            pre16 <= '0;
            pre17 <= '0;
            pre18 <= '0;
            cnt_q <= '0;
            hit_o <= 1'b0;
            golden_o <= '0;
        end else begin
            hit_o <= 1'b0;
            if (load_i) begin
                mid_q <= mid_in;
                tw_q[0] <= tail_i[95:64];
                tw_q[1] <= tail_i[63:32];
                tw_q[2] <= tail_i[31:0];
                pre16 <= ld16;
                pre17 <= ld17;
                pre18 <= tail_i[31:0] + small_sig1(ld16);
                cnt_q <= nonce_start_i;
                golden_o <= '0;
                rnd <= '0;
                ph <= PH_ISSUE;
            end else begin
                case (ph)
                    PH_ISSUE: begin
                        st_q <= mid_q;
                        cnt_q <= cnt_q + 32'd1;
                        rnd <= '0;
                        ph <= PH_P1;
                    end
                    PH_P1: begin
                        if (rnd == P1_LAST) begin
                            st_q <= iv_st;
                            rnd <= '0;
                            ph <= PH_P2;
                        end else begin
                            st_q <= st_nxt;
                            rnd <= rnd + RW'(1);
                        end
                    end
                    PH_P2: begin
                        st_q <= st_nxt;
                        if (rnd == P2_LAST) begin
                            rnd <= '0;
                            ph <= PH_ISSUE;
                            if (match) begin
                                hit_o <= 1'b1;
                                golden_o <= cnt_q - 32'd1;
                            end
                        end else begin
                            rnd <= rnd + RW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dsha_checker.sv
// Protocol checks on the nonce search engine, bound to every instance of the top.
// Assumes the phase encoding idle=0, issue=1, first pass=2, second pass=3.
module dsha_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load_i,
    input logic        hit_o,
    input logic [31:0] golden_o,
    input logic [1:0]  phase_i
);
    logic [7:0] since_load;

    // Count cycles since the last load, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_load <= '0;
        else if (load_i)           since_load <= '0;
        else if (since_load != 8'hFF) since_load <= since_load + 8'd1;
    end

    assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
    assert_golden_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (hit_o || $stable(golden_o)));
    assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!hit_o && golden_o == 32'd0));
    assert_first_hit_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> since_load >= 8'd126);
    assert_hit_after_second_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(phase_i) == 2'd3);
endmodule

bind dsha_nonce_tester dsha_checker u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .hit_o(hit_o),
    .golden_o(golden_o), .phase_i(ph));

// File: tb/dsha_nonce_tester_test.sv
// Scoreboard bench: the driver pushes expected hits from a full double-hash model,
// and the monitor pops and compares them as the design reports.
module dsha_nonce_tester_test;
    localparam logic [31:0] MASK = 32'h0000_0003;
    localparam int TRIAL = 126;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [255:0] midstate_i = '0;
    logic [95:0]  tail_i = '0;
    logic [31:0]  nonce_start_i = '0;
    logic         hit_o;
    logic [31:0]  golden_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] exp_nonce_q [$];
    int          exp_cyc_q [$];

    dsha_nonce_tester #(.HIT_MASK(MASK)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .midstate_i(midstate_i),
        .tail_i(tail_i), .nonce_start_i(nonce_start_i), .hit_o(hit_o), .golden_o(golden_o));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // Full 64-round compression, reference model.
    function automatic logic [255:0] compress(input logic [255:0] st, input logic [511:0] blk);
        logic [31:0] w [64];
        logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
        for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
        {a, b, c, d, e, f, g, h} = st;
        for (int t = 0; t < 64; t++) begin
            x1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) | (~e & g)) + dsha_pkg::K_TAB[t] + w[t];
            x2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) | (c & (a | b)));
            h = g; g = f; f = e; e = d + x1; d = c; c = b; b = a; a = x1 + x2;
        end
        return {a, b, c, d, e, f, g, h};
    endfunction

    function automatic logic [255:0] addw(input logic [255:0] p, input logic [255:0] q);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[32*i +: 32] = p[32*i +: 32] + q[32*i +: 32];
        return r;
    endfunction

    function automatic logic [31:0] last_word(input logic [255:0] mid, input logic [95:0] tl, input logic [31:0] n);
        logic [255:0] iv, d1, d2;
        iv = 256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
        d1 = addw(mid, compress(mid, {tl, n, 32'h8000_0000, 320'b0, 32'd640}));
        d2 = addw(iv, compress(iv, {d1, 32'h8000_0000, 192'b0, 32'd256}));
        return d2[31:0];
    endfunction

    task automatic check(input logic ok, input string req, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: predict hits, load the unit, optionally disturb the inputs, wait, close out.
    task automatic run_unit(input logic [255:0] mid, input logic [95:0] tl, input logic [31:0] start,
                            input int n, input bit garble);
        logic [31:0] last = 32'd0;
        int ld_mark;
        @(negedge clk);
        ld_mark = cyc + 1;
        for (int k = 0; k < n; k++) begin
            if ((last_word(mid, tl, start + 32'(k)) & MASK) == 32'd0) begin
                exp_nonce_q.push_back(start + 32'(k));
                exp_cyc_q.push_back(ld_mark + TRIAL * (k + 1));
                last = start + 32'(k);
            end
        end
        midstate_i = mid;
        tail_i = tl;
        nonce_start_i = start;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        check(!hit_o && golden_o == 32'd0, "R8", "outputs cleared after load", {hit_o, golden_o}, 0);
        if (garble) begin
            // R6: ports changed after load must not affect the search
            midstate_i = ~mid;
            tail_i = ~tl;
            nonce_start_i = start ^ 32'h5555_0000;
        end
        repeat (TRIAL * n + 1) @(negedge clk);
        check(exp_nonce_q.size() == 0, "R2", "all predicted hits reported", exp_nonce_q.size(), 0);
        exp_nonce_q.delete();
        exp_cyc_q.delete();
        check(golden_o == last, "R7", "golden holds last hit", golden_o, last);
    endtask

    // Monitor: pop the scoreboard on every strobe and compare nonce and arrival cycle.
    always @(negedge clk) begin
        if (rst_n && hit_o) begin
            if (exp_nonce_q.size() == 0) begin
                check(1'b0, "R5", "unexpected hit", golden_o, 0);
            end else begin
                logic [31:0] en;
                int ec;
                en = exp_nonce_q.pop_front();
                ec = exp_cyc_q.pop_front();
                check(golden_o == en, "R3 R4 R5", "golden nonce", golden_o, en);
                check(cyc == ec, "R9", "hit cycle", cyc, ec);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        check(!hit_o && golden_o == 32'd0, "R1", "reset state", {hit_o, golden_o}, 0);
        repeat (200) @(negedge clk);
        check(!hit_o && golden_o == 32'd0, "R1", "idle without load", {hit_o, golden_o}, 0);
        run_unit({8{32'h0123_4567}} ^ 256'h89ab_cdef, 96'hdead_beef_0bad_f00d_1357_9bdf, 32'h0000_1000, 24, 1'b0);
        run_unit(256'hfeed_face_cafe_babe_0011_2233_4455_6677_8899_aabb_ccdd_eeff_1020_3040_5060_7080,
                 96'h1111_2222_3333_4444_5555_6666, 32'h7000_0000, 20, 1'b1);
        run_unit({8{32'ha5a5_5a5a}}, 96'h0, 32'hFFFF_FFF8, 16, 1'b0);   // R2 wrap
        run_unit({8{32'h3c3c_c3c3}}, 96'hffff_ffff_0000_0001_8000_0000, 32'h0000_0000, 12, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule